// File: doc/BRIEF.md
# Sprite Slot Upload Port

This block is the processor-facing loading path of a sprite engine. A processor writes a slot number once through the select port. That one write loads two separate indices: one for the per-sprite attribute table and one for the pattern pixel store. From then on, the attribute data port and the pattern data port each step their own index. The processor can therefore stream pixel bytes and sprite records without reselecting the slot.

Attribute records are either four or five bytes long. A small state machine counts the bytes of the current record. When the record closes, the machine moves the attribute slot on by one. Each pattern slot holds 256 bytes. The select write can start pattern loading at the middle of the slot instead of at the start. The pattern address then runs straight through slot boundaries.

The renderer reports two events with one-cycle pulses: a pixel collision and running out of time on a line. The block latches each event in a sticky flag. A status read returns both flags and then clears them. The block drives write-enable, address and data lines towards an attribute RAM and a pattern RAM. Those RAMs and the renderer sit outside this block.

Attribute byte counter states and transitions:
- States: REC_B0, REC_B1, REC_B2, REC_B3, REC_B4.
- ADVANCE steps B0 to B1, B1 to B2 and B2 to B3 on each attribute write.
- CLOSE_SHORT goes from B3 to B0 and bumps the slot.
- EXTEND goes from B3 to B4.
- CLOSE_LONG goes from B4 to B0 and bumps the slot.
- RESYNC sends any state to B0 on a select write and loads the slot.

Top module: `sprite_upload_port`

## Requirements
- R1: After reset, attr_addr and pat_addr are 0, stat_data is 0, and attr_we and pat_we are low while no write is requested.
- R2: A select write loads sel_data[5:0] as both the attribute slot and the pattern slot. Afterwards attr_addr = {slot, 3'd0} and pat_addr = {slot, 8'h00} when sel_data[7] is 0. sel_data[6] has no effect.
- R3: A select write with sel_data[7] = 1 sets pat_addr = {slot, 8'h80}, so pattern loading starts at byte 128 of the slot.
- R4: On a pattern write cycle, pat_we is high and pat_wdata equals pat_data. pat_addr gives the target as {slot, byte} and then increments by one. Byte 255 moves on to byte 0 of the next slot, and slot 63 byte 255 moves on to address 0.
- R5: On an attribute write cycle, attr_we is high, attr_wdata equals attr_data and attr_addr = {slot, byte index}. A record whose 4th byte has bit 6 clear ends after 4 bytes, and the slot then increments.
- R6: A record whose 4th byte has bit 6 set takes a 5th byte at byte index 4, and the slot then increments. The byte index never exceeds 4.
- R7: Pattern writes leave attr_addr unchanged, and attribute writes leave pat_addr unchanged.
- R8: The attribute slot moves on from 63 to 0 when a record closes.
- R9: A select write in the middle of a record restarts the byte index at 0 in the new slot.
- R10: stat_data bit 0 is the collision flag and bit 1 is the line-overflow flag. Bits 7..2 read 0. A flag goes high the cycle after its set pulse and stays high until it is read.
- R11: A status read clears both flags after the read cycle. A set pulse in the same cycle as the read leaves its flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Select port write strobe |
| sel_data | input | 8 | Select value: [5:0] slot, [7] half-slot pattern start |
| attr_wr | input | 1 | Attribute data port write strobe |
| attr_data | input | 8 | Attribute record byte |
| pat_wr | input | 1 | Pattern data port write strobe |
| pat_data | input | 8 | Pattern pixel byte |
| stat_rd | input | 1 | Status read strobe; clears flags |
| coll_set | input | 1 | Renderer pulse: collision seen |
| ovf_set | input | 1 | Renderer pulse: line time exhausted |
| stat_data | output | 8 | Status byte {6'b0, overflow, collision} |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 9 | Attribute RAM address {slot, byte index} |
| attr_wdata | output | 8 | Attribute RAM write data |
| pat_we | output | 1 | Pattern RAM write enable |
| pat_addr | output | 14 | Pattern RAM address {slot, byte} |
| pat_wdata | output | 8 | Pattern RAM write data |

## Verification
Some internal faults show up at the ports, and quickly:
- A wrong record byte count or slot index appears on attr_addr at the very next attribute write.
- A bad pattern pointer appears on pat_addr at once, because pat_addr presents the pointer continuously.
- A flag that fails to latch, fails to clear, or loses a pulse that coincides with a read becomes visible on stat_data one cycle later.

The directed tests therefore check the address after each write and the status byte one cycle after each pulse or read. They also cover the slot 63 wrap on both ports, the half-slot start, records of both lengths, and a reselect in the middle of a record.

// File: rtl/sprite_upload_pkg.sv
package sprite_upload_pkg;

    // Width of the byte index inside an attribute record.
    localparam int REC_IDX_W   = 3;

    // Bit of the 4th record byte that requests a 5th byte.
    localparam int EXT_FLAG_BIT = 6;

    // Number of renderer flags held in the status byte.
    localparam int N_FLAGS     = 2;

    // Bit positions of the renderer flags in the status byte.
    localparam int FLAG_COLL   = 0;
    localparam int FLAG_OVF    = 1;

    // Attribute record byte counter.
    typedef enum logic [REC_IDX_W-1:0] {
        REC_B0 = 3'd0,
        REC_B1 = 3'd1,
        REC_B2 = 3'd2,
        REC_B3 = 3'd3,
        REC_B4 = 3'd4
    } rec_state_e;

endpackage

// File: rtl/attr_sequencer.sv
module attr_sequencer
    import sprite_upload_pkg::*;
#(
    parameter int SLOT_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_wr,
    input  logic [SLOT_W-1:0]             sel_slot,
    input  logic                          wr,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          we,
    output logic [SLOT_W+REC_IDX_W-1:0]   addr,
    output logic [DATA_W-1:0]             wdata_o
);

    rec_state_e            state_q, state_d;
    logic [SLOT_W-1:0]     slot_q, slot_d;
    logic [REC_IDX_W-1:0]  byte_idx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REC_B0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next-state logic: RESYNC, ADVANCE, EXTEND, CLOSE_SHORT, CLOSE_LONG.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        if (sel_wr) begin
            // RESYNC
            state_d = REC_B0;
            slot_d  = sel_slot;
        end else if (wr) begin
            unique case (state_q)
                REC_B0: state_d = REC_B1;
                REC_B1: state_d = REC_B2;
                REC_B2: state_d = REC_B3;
                REC_B3: begin
                    if (wdata[EXT_FLAG_BIT]) begin
                        // EXTEND
                        state_d = REC_B4;
                    end else begin
                        // CLOSE_SHORT
                        state_d = REC_B0;
                        slot_d  = slot_q + 1'b1;
                    end
                end
                REC_B4: begin
                    // CLOSE_LONG
                    state_d = REC_B0;
                    slot_d  = slot_q + 1'b1;
                end
                default: state_d = REC_B0;
            endcase
        end
    end

    // Output logic.
    always_comb begin
        we      = wr;
        wdata_o = wdata;
        unique case (state_q)
            REC_B0:  byte_idx = 3'd0;
            REC_B1:  byte_idx = 3'd1;
            REC_B2:  byte_idx = 3'd2;
            REC_B3:  byte_idx = 3'd3;
            REC_B4:  byte_idx = 3'd4;
            default: byte_idx = 3'd0;
        endcase
        addr = {slot_q, byte_idx};
    end

endmodule

// File: rtl/pattern_pointer.sv
module pattern_pointer #(
    parameter int SLOT_W = 6,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_wr,
    input  logic [SLOT_W-1:0]          sel_slot,
    input  logic                       sel_half,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wdata,
    output logic                       we,
    output logic [SLOT_W+BYTE_W-1:0]   addr,
    output logic [DATA_W-1:0]          wdata_o
);

    localparam int ADDR_W = SLOT_W + BYTE_W;

    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [BYTE_W-1:0] start_byte;

    // Start byte: 0 or the middle of the slot.
    always_comb begin
        start_byte = '0;
        start_byte[BYTE_W-1] = sel_half;
    end

    always_comb begin
        ptr_d = ptr_q;
        if (sel_wr) begin
            ptr_d = {sel_slot, start_byte};
        end else if (wr) begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        we      = wr;
        addr    = ptr_q;
        wdata_o = wdata;
    end

endmodule

// File: rtl/status_flags.sv
module status_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);

    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (rd) begin
                // A pulse arriving with the read survives it.
                flag_q[i] <= set[i];
            end else if (set[i]) begin
                flag_q[i] <= 1'b1;
            end
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/sprite_upload_port.sv
module sprite_upload_port
    import sprite_upload_pkg::*;
#(
    parameter int SLOT_W = 6,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel_wr,
    input  logic [DATA_W-1:0]            sel_data,
    input  logic                         attr_wr,
    input  logic [DATA_W-1:0]            attr_data,
    input  logic                         pat_wr,
    input  logic [DATA_W-1:0]            pat_data,
    input  logic                         stat_rd,
    input  logic                         coll_set,
    input  logic                         ovf_set,
    output logic [DATA_W-1:0]            stat_data,
    output logic                         attr_we,
    output logic [SLOT_W+REC_IDX_W-1:0]  attr_addr,
    output logic [DATA_W-1:0]            attr_wdata,
    output logic                         pat_we,
    output logic [SLOT_W+BYTE_W-1:0]     pat_addr,
    output logic [DATA_W-1:0]            pat_wdata
);

    localparam int HALF_BIT = DATA_W - 1;

    logic [SLOT_W-1:0]  sel_slot;
    logic               sel_half;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flags;
    logic               unused_sel_bits;

    assign sel_slot        = sel_data[SLOT_W-1:0];
    assign sel_half        = sel_data[HALF_BIT];
    assign unused_sel_bits = ^sel_data[HALF_BIT-1:SLOT_W];

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_COLL] = coll_set;
        flag_set[FLAG_OVF]  = ovf_set;
    end

    attr_sequencer #(
        .SLOT_W (SLOT_W),
        .DATA_W (DATA_W)
    ) u_attr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_slot (sel_slot),
        .wr       (attr_wr),
        .wdata    (attr_data),
        .we       (attr_we),
        .addr     (attr_addr),
        .wdata_o  (attr_wdata)
    );

    pattern_pointer #(
        .SLOT_W (SLOT_W),
        .BYTE_W (BYTE_W),
        .DATA_W (DATA_W)
    ) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_slot (sel_slot),
        .sel_half (sel_half),
        .wr       (pat_wr),
        .wdata    (pat_data),
        .we       (pat_we),
        .addr     (pat_addr),
        .wdata_o  (pat_wdata)
    );

    status_flags #(
        .N (N_FLAGS)
    ) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (stat_rd),
        .set   (flag_set),
        .flags (flags)
    );

    assign stat_data = {{(DATA_W-N_FLAGS){1'b0}}, flags};

endmodule

// File: rtl/sprite_upload_port_sva.sv
module sprite_upload_port_sva #(
    parameter int SLOT_W = 6,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sel_wr,
    input logic [DATA_W-1:0]           sel_data,
    input logic                        attr_wr,
    input logic                        pat_wr,
    input logic                        stat_rd,
    input logic                        coll_set,
    input logic                        ovf_set,
    input logic [DATA_W-1:0]           stat_data,
    input logic [SLOT_W+2:0]           attr_addr,
    input logic [SLOT_W+BYTE_W-1:0]    pat_addr
);

    AST_SEL_PAT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> pat_addr == {$past(sel_data[SLOT_W-1:0]), $past(sel_data[DATA_W-1]), {(BYTE_W-1){1'b0}}}); // R3

    AST_SEL_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> attr_addr == {$past(sel_data[SLOT_W-1:0]), 3'd0}); // R9

    AST_PAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_wr && !sel_wr) |=> pat_addr == $past(pat_addr) + 1'b1); // R4

    AST_PAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pat_wr && !sel_wr) |=> $stable(pat_addr)); // R7

    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!attr_wr && !sel_wr) |=> $stable(attr_addr)); // R7

    AST_IDX_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        attr_addr[2:0] <= 3'd4); // R6

    AST_LONG_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_wr && !sel_wr && attr_addr[2:0] == 3'd4)
        |=> attr_addr == {$past(attr_addr[SLOT_W+2:3]) + 1'b1, 3'd0}); // R6

    AST_STAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stat_data[DATA_W-1:2] == '0); // R10

    AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        coll_set |=> stat_data[0]); // R11

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> stat_data[1]); // R11

    AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !coll_set && !ovf_set) |=> stat_data[1:0] == 2'b00); // R11

endmodule

bind sprite_upload_port sprite_upload_port_sva #(
    .SLOT_W (SLOT_W),
    .BYTE_W (BYTE_W),
    .DATA_W (DATA_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_data  (sel_data),
    .attr_wr   (attr_wr),
    .pat_wr    (pat_wr),
    .stat_rd   (stat_rd),
    .coll_set  (coll_set),
    .ovf_set   (ovf_set),
    .stat_data (stat_data),
    .attr_addr (attr_addr),
    .pat_addr  (pat_addr)
);

// File: tb/sprite_upload_port_bench.sv
module sprite_upload_port_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [7:0]  sel_data = '0;
    logic        attr_wr = 1'b0;
    logic [7:0]  attr_data = '0;
    logic        pat_wr = 1'b0;
    logic [7:0]  pat_data = '0;
    logic        stat_rd = 1'b0;
    logic        coll_set = 1'b0;
    logic        ovf_set = 1'b0;
    logic [7:0]  stat_data;
    logic        attr_we;
    logic [8:0]  attr_addr;
    logic [7:0]  attr_wdata;
    logic        pat_we;
    logic [13:0] pat_addr;
    logic [7:0]  pat_wdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sprite_upload_port u_sprite_upload_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .sel_data   (sel_data),
        .attr_wr    (attr_wr),
        .attr_data  (attr_data),
        .pat_wr     (pat_wr),
        .pat_data   (pat_data),
        .stat_rd    (stat_rd),
        .coll_set   (coll_set),
        .ovf_set    (ovf_set),
        .stat_data  (stat_data),
        .attr_we    (attr_we),
        .attr_addr  (attr_addr),
        .attr_wdata (attr_wdata),
        .pat_we     (pat_we),
        .pat_addr   (pat_addr),
        .pat_wdata  (pat_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_sel(input logic [7:0] v);
        @(negedge clk);
        sel_wr = 1'b1; sel_data = v;
        @(posedge clk); #1;
        sel_wr = 1'b0;
        @(negedge clk);
    endtask

    // Attribute write: checks strobe, data and address in the write cycle.
    task automatic attr_write(input logic [7:0] d, input logic [5:0] slot,
                              input logic [2:0] idx, input string req);
        @(negedge clk);
        attr_wr = 1'b1; attr_data = d;
        #1;
        chk(req, {31'd0, attr_we}, 32'd1);
        chk(req, {24'd0, attr_wdata}, {24'd0, d});
        chk(req, {23'd0, attr_addr}, {23'd0, slot, idx});
        @(posedge clk); #1;
        attr_wr = 1'b0;
    endtask

    task automatic pat_write(input logic [7:0] d, input logic [13:0] exp_addr, input string req);
        @(negedge clk);
        pat_wr = 1'b1; pat_data = d;
        #1;
        chk(req, {31'd0, pat_we}, 32'd1);
        chk(req, {24'd0, pat_wdata}, {24'd0, d});
        chk(req, {18'd0, pat_addr}, {18'd0, exp_addr});
        @(posedge clk); #1;
        pat_wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 attr_addr", {23'd0, attr_addr}, 32'd0);
        chk("R1 pat_addr", {18'd0, pat_addr}, 32'd0);
        chk("R1 stat", {24'd0, stat_data}, 32'd0);
        chk("R1 we", {30'd0, attr_we, pat_we}, 32'd0);
    endtask

    task automatic t_select();
        do_sel(8'h25);
        chk("R2 attr", {23'd0, attr_addr}, {23'd0, 6'h25, 3'd0});
        chk("R2 pat", {18'd0, pat_addr}, {18'd0, 6'h25, 8'h00});
        do_sel(8'h45);   // bit 6 has no effect
        chk("R2 bit6 attr", {23'd0, attr_addr}, {23'd0, 6'h05, 3'd0});
        chk("R2 bit6 pat", {18'd0, pat_addr}, {18'd0, 6'h05, 8'h00});
        do_sel(8'hA5);
        chk("R3 half", {18'd0, pat_addr}, {18'd0, 6'h25, 8'h80});
        chk("R3 attr", {23'd0, attr_addr}, {23'd0, 6'h25, 3'd0});
    endtask

    task automatic t_pattern();
        do_sel(8'h83);
        for (int i = 0; i < 128; i++) begin
            pat_write(8'(i ^ 8'h5A), {6'd3, 8'(128 + i)}, "R4 stream");
        end
        @(negedge clk);
        chk("R4 slot cross", {18'd0, pat_addr}, {18'd0, 6'd4, 8'h00});
        chk("R7 attr untouched", {23'd0, attr_addr}, {23'd0, 6'd3, 3'd0});
        do_sel(8'hBF);
        for (int i = 0; i < 128; i++) begin
            pat_write(8'(i), {6'd63, 8'(128 + i)}, "R4 last slot");
        end
        @(negedge clk);
        chk("R4 wrap to 0", {18'd0, pat_addr}, 32'd0);
    endtask

    task automatic t_attr_short();
        do_sel(8'h0A);
        attr_write(8'h11, 6'd10, 3'd0, "R5 b0");
        attr_write(8'h22, 6'd10, 3'd1, "R5 b1");
        attr_write(8'h33, 6'd10, 3'd2, "R5 b2");
        attr_write(8'hBF, 6'd10, 3'd3, "R5 b3");
        @(negedge clk);
        chk("R5 next slot", {23'd0, attr_addr}, {23'd0, 6'd11, 3'd0});
        chk("R7 pat untouched", {18'd0, pat_addr}, {18'd0, 6'd10, 8'h00});
    endtask

    task automatic t_attr_long();
        do_sel(8'h0C);
        attr_write(8'h01, 6'd12, 3'd0, "R6 b0");
        attr_write(8'h02, 6'd12, 3'd1, "R6 b1");
        attr_write(8'h03, 6'd12, 3'd2, "R6 b2");
        attr_write(8'h40, 6'd12, 3'd3, "R6 b3");
        attr_write(8'h05, 6'd12, 3'd4, "R6 b4");
        @(negedge clk);
        chk("R6 next slot", {23'd0, attr_addr}, {23'd0, 6'd13, 3'd0});
    endtask

    task automatic t_attr_wrap();
        do_sel(8'h3F);
        attr_write(8'h00, 6'd63, 3'd0, "R8 b0");
        attr_write(8'h00, 6'd63, 3'd1, "R8 b1");
        attr_write(8'h00, 6'd63, 3'd2, "R8 b2");
        attr_write(8'h00, 6'd63, 3'd3, "R8 b3");
        @(negedge clk);
        chk("R8 wrap", {23'd0, attr_addr}, 32'd0);
    endtask

    task automatic t_midsel();
        do_sel(8'h14);
        attr_write(8'hAA, 6'd20, 3'd0, "R9 pre b0");
        attr_write(8'hAA, 6'd20, 3'd1, "R9 pre b1");
        do_sel(8'h1E);
        chk("R9 restart", {23'd0, attr_addr}, {23'd0, 6'd30, 3'd0});
        attr_write(8'h10, 6'd30, 3'd0, "R9 b0");
        attr_write(8'h20, 6'd30, 3'd1, "R9 b1");
        attr_write(8'h30, 6'd30, 3'd2, "R9 b2");
        attr_write(8'h00, 6'd30, 3'd3, "R9 b3");
        @(negedge clk);
        chk("R9 close", {23'd0, attr_addr}, {23'd0, 6'd31, 3'd0});
    endtask

    task automatic t_status();
        @(negedge clk);
        chk("R10 idle", {24'd0, stat_data}, 32'd0);
        coll_set = 1'b1;
        @(posedge clk); #1; coll_set = 1'b0;
        @(negedge clk);
        chk("R10 coll", {24'd0, stat_data}, 32'h01);
        repeat (3) @(negedge clk);
        chk("R10 sticky", {24'd0, stat_data}, 32'h01);
        ovf_set = 1'b1;
        @(posedge clk); #1; ovf_set = 1'b0;
        @(negedge clk);
        chk("R10 both", {24'd0, stat_data}, 32'h03);
        stat_rd = 1'b1;
        #1;
        chk("R11 read value", {24'd0, stat_data}, 32'h03);
        @(posedge clk); #1; stat_rd = 1'b0;
        @(negedge clk);
        chk("R11 cleared", {24'd0, stat_data}, 32'h00);
        ovf_set = 1'b1;
        @(posedge clk); #1; ovf_set = 1'b0;
        @(negedge clk);
        chk("R10 ovf only", {24'd0, stat_data}, 32'h02);
        stat_rd = 1'b1; coll_set = 1'b1;
        @(posedge clk); #1; stat_rd = 1'b0; coll_set = 1'b0;
        @(negedge clk);
        chk("R11 pulse on read", {24'd0, stat_data}, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_pattern();
        t_attr_short();
        t_attr_long();
        t_attr_wrap();
        t_midsel();
        t_status();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule